// File: doc/BRIEF.md
# Per-core routed level interrupt fan-out

This block collects a set of level-sensitive peripheral interrupt lines and steers each of them onto one of several level outputs for every processor core that it serves. Each core owns a private bank made of an enable mask and a group of routing words. A routing word holds one 4-bit code per input. A code of zero leaves the input unconnected for that core. A nonzero code n drives output line n-1 of that core. The same input can go to different lines on different cores, it can go to one core only, or it can be cut off everywhere.

Software reaches both banks through one small word-addressed register port, and a core-index field picks the bank. Inputs are synchronized to the block clock, and a shared read-only status word shows them. For each core, every output line is the OR of all inputs that are synchronized high, enabled in that core's mask and coded for that line. The result is registered once before it leaves the block, so the outputs can drive the cores' interrupt pins directly.

Top module: `pirq_router`

## Requirements
- R1: Every input passes through a two-flop synchronizer. The status word at byte offset 0x04 reads each input's level as sampled two clock edges earlier, with input i at bit i. Both banks return the same status value.
- R2: The status word is read-only. A write to offset 0x04 changes no mask, no routing word and no output.
- R3: The mask word at offset 0x00 holds one enable bit per input, with input i at bit i. An input is pending for a core only when its synchronized level and that core's mask bit are both 1. A core whose mask is all zero drives all of its lines low.
- R4: A routing code of 0 disconnects the input for that core. A code n in 1..15 sends the input to output line n-1 of that core.
- R5: The routing codes are packed eight per word: inputs 0-7 at offset 0x14, 8-15 at 0x10, 16-23 at 0x0C and 24-31 at 0x08. Input i occupies bits [4*(i mod 8)+3 : 4*(i mod 8)] of its word, and each word reads back as written.
- R6: `bus_core` selects which core's bank a read or write reaches. Line k of core c is output bit c*15+k, and a write to one bank never changes the other bank's outputs.
- R7: Output line k of core c is 1 exactly when some input is pending for core c with code k+1. It is registered, so it follows a register write one edge after the write edge and an input change three edges after the input is sampled.
- R8: Byte enable bit b writes byte lane b (bits 8b+7..8b) of the mask or routing word. Lanes whose enable is 0 keep their contents, and a write with no enable set changes nothing.
- R9: Reset clears every mask and routing word in both banks and drives every output low.
- R10: Offsets 0x18 and 0x1C and any offset that is not a multiple of 4 read as zero and ignore writes.
- R11: Several pending inputs coded to the same line of one core OR together onto that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level interrupt inputs, asynchronous to clk |
| bus_core | input | 1 | Bank (core index) selected by the register port |
| bus_addr | input | 5 | Byte offset of the register word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane write enables |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| core_irq | output | 30 | Registered level lines, core c line k at bit c*15+k |

## Verification
The case that needs the most care is a mask or routing write that lands on the same clock edge as an input transition leaving the synchronizer. The output register must then combine the old configuration with the newly visible level on that edge, and the new configuration from the next edge on. The bench creates this overlap in a random phase, where inputs toggle and register writes are issued back to back every cycle. It judges each cycle's 30 output bits against a behavioural model that applies writes and input sampling in that order at each edge. Directed steps pin the one-edge lag after a write and the two-edge lag of the status word on their own.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

   // word indices (byte offset / 4) inside one core bank
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned MASK_IX  = 0;
   localparam int unsigned STAT_IX  = 1;
   localparam int unsigned RT_BASE  = 2;

   typedef logic [WORD_W-1:0] word_t;

   // routing word index holding input group g (inputs 8g..8g+7):
   // the lowest group sits in the highest-addressed word
   function automatic int unsigned rt_slot(input int unsigned g, input int unsigned n_rt);
      return RT_BASE + (n_rt - 1 - g);
   endfunction

endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) stg[s] <= '0;
         end else begin
            stg[0] <= d;
            for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
         end
      end

      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/pirq_bank.sv
module pirq_bank
   import pirq_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned CODE_W = 4,
   parameter int unsigned WIX_W  = 3,
   localparam int unsigned PER_W = WORD_W / CODE_W,
   localparam int unsigned N_RT  = N_SRC / PER_W,
   localparam int unsigned N_MB  = N_SRC / 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [WIX_W-1:0]         widx,
   input  word_t                    wdata,
   input  logic [3:0]               be,
   input  logic [N_SRC-1:0]         status,
   output logic [N_SRC-1:0]         mask_q,
   output logic [N_SRC*CODE_W-1:0] codes,
   output word_t                    rdata
);

   word_t rt_q [N_RT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         for (int g = 0; g < int'(N_RT); g++) rt_q[g] <= '0;
      end else if (wr_en) begin
         if (int'(widx) == int'(MASK_IX)) begin
            for (int b = 0; b < int'(N_MB); b++)
               if (be[b]) mask_q[8*b +: 8] <= wdata[8*b +: 8];
         end
         for (int g = 0; g < int'(N_RT); g++) begin
            if (int'(widx) == int'(rt_slot(g, N_RT))) begin
               for (int b = 0; b < 4; b++)
                  if (be[b]) rt_q[g][8*b +: 8] <= wdata[8*b +: 8];
            end
         end
      end
   end

   // unpack one code per input from the group words
   for (genvar i = 0; i < int'(N_SRC); i++) begin : g_code
      assign codes[i*CODE_W +: CODE_W] = rt_q[i / PER_W][(i % PER_W)*CODE_W +: CODE_W];
   end

   always_comb begin
      rdata = '0;
      if (int'(widx) == int'(MASK_IX)) begin
         rdata[N_SRC-1:0] = mask_q;
      end else if (int'(widx) == int'(STAT_IX)) begin
         rdata[N_SRC-1:0] = status;
      end else begin
         for (int g = 0; g < int'(N_RT); g++)
            if (int'(widx) == int'(rt_slot(g, N_RT))) rdata = rt_q[g];
      end
   end

endmodule

// File: rtl/pirq_route_dec.sv
module pirq_route_dec #(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned N_LINE = 15,
   parameter int unsigned CODE_W = 4
) (
   input  logic [N_SRC-1:0]         status,
   input  logic [N_SRC-1:0]         mask,
   input  logic [N_SRC*CODE_W-1:0] codes,
   output logic [N_LINE-1:0]        lines
);

   logic [N_SRC-1:0] pend;
   assign pend = status & mask;

   for (genvar k = 0; k < int'(N_LINE); k++) begin : g_line
      logic [N_SRC-1:0] hit;
      for (genvar i = 0; i < int'(N_SRC); i++) begin : g_src
         assign hit[i] = pend[i] && (codes[i*CODE_W +: CODE_W] == CODE_W'(k + 1));
      end
      assign lines[k] = |hit;
   end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
   import pirq_pkg::*;
#(
   parameter int unsigned N_SRC       = 32,
   parameter int unsigned N_LINE      = 15,
   parameter int unsigned N_CORE      = 2,
   parameter int unsigned CODE_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned AW          = 5,
   localparam int unsigned CW    = (N_CORE > 1) ? $clog2(N_CORE) : 1,
   localparam int unsigned WIX_W = AW - 2,
   localparam int unsigned OUT_W = N_CORE * N_LINE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_in,
   input  logic [CW-1:0]     bus_core,
   input  logic [AW-1:0]     bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic [3:0]        bus_be,
   output logic [31:0]       bus_rdata,
   output logic [OUT_W-1:0]  core_irq
);

   localparam int unsigned N_RT = N_SRC * CODE_W / WORD_W;

   // elaboration-time parameter checks
   if ((N_SRC % 8) != 0 || N_SRC > WORD_W || N_SRC == 0) begin : g_bad_src
      $error("pirq_router: N_SRC must be a nonzero multiple of 8, at most 32");
   end
   if ((WORD_W % CODE_W) != 0) begin : g_bad_code
      $error("pirq_router: CODE_W must divide the word width");
   end
   if (N_LINE > (1 << CODE_W) - 1 || N_LINE == 0) begin : g_bad_line
      $error("pirq_router: N_LINE must be 1 .. 2**CODE_W-1");
   end
   if ((1 << WIX_W) < RT_BASE + N_RT) begin : g_bad_aw
      $error("pirq_router: AW too small for the register bank");
   end

   logic [N_SRC-1:0]        status_q;
   logic [N_CORE*N_SRC-1:0] mask_flat;
   word_t                   bank_rdata [N_CORE];
   logic                    aligned;
   logic [WIX_W-1:0]        widx;

   assign aligned = (bus_addr[1:0] == 2'b00);
   assign widx    = bus_addr[AW-1:2];

   pirq_sync #(
      .W      (N_SRC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_in),
      .q     (status_q)
   );

   for (genvar c = 0; c < int'(N_CORE); c++) begin : g_core
      logic [N_SRC-1:0]         mask_c;
      logic [N_SRC*CODE_W-1:0] codes_c;
      logic [N_LINE-1:0]        lines_c;
      logic [N_LINE-1:0]        line_q;
      logic                     wr_c;

      assign wr_c = bus_wr && aligned && (int'(bus_core) == c);

      pirq_bank #(
         .N_SRC  (N_SRC),
         .CODE_W (CODE_W),
         .WIX_W  (WIX_W)
      ) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (wr_c),
         .widx   (widx),
         .wdata  (bus_wdata),
         .be     (bus_be),
         .status (status_q),
         .mask_q (mask_c),
         .codes  (codes_c),
         .rdata  (bank_rdata[c])
      );

      pirq_route_dec #(
         .N_SRC  (N_SRC),
         .N_LINE (N_LINE),
         .CODE_W (CODE_W)
      ) u_dec (
         .status (status_q),
         .mask   (mask_c),
         .codes  (codes_c),
         .lines  (lines_c)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line_q <= '0;
         else        line_q <= lines_c;
      end

      assign core_irq[c*N_LINE +: N_LINE] = line_q;
      assign mask_flat[c*N_SRC +: N_SRC]  = mask_c;
   end

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < int'(N_CORE); c++)
         if (aligned && int'(bus_core) == c) bus_rdata = bank_rdata[c];
   end

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned N_LINE = 15,
   parameter int unsigned N_CORE = 2,
   parameter int unsigned AW     = 5
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [N_SRC-1:0]         irq_in,
   input logic [N_SRC-1:0]         status,
   input logic                     bus_wr,
   input logic [AW-1:0]            bus_addr,
   input logic [3:0]               bus_be,
   input logic [N_CORE*N_SRC-1:0]  mask_flat,
   input logic [N_CORE*N_LINE-1:0] core_irq
);

   logic [1:0] live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          live <= '0;
      else if (live != 2'd3) live <= live + 2'd1;
   end

   AST_STATUS_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
      (live >= 2'd2) |-> (status == $past(irq_in, 2))); // R1

   AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'(4)) |=> $stable(mask_flat)); // R2

   AST_NO_LANE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_be == 4'b0000) |=> $stable(mask_flat)); // R8

   for (genvar c = 0; c < int'(N_CORE); c++) begin : g_core
      AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_flat[c*N_SRC +: N_SRC] == '0) |=> (core_irq[c*N_LINE +: N_LINE] == '0)); // R3

      AST_LINE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
         ((status & mask_flat[c*N_SRC +: N_SRC]) == '0) |=> (core_irq[c*N_LINE +: N_LINE] == '0)); // R7
   end

endmodule

bind pirq_router pirq_router_chk #(
   .N_SRC  (N_SRC),
   .N_LINE (N_LINE),
   .N_CORE (N_CORE),
   .AW     (AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_in    (irq_in),
   .status    (status_q),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_be    (bus_be),
   .mask_flat (mask_flat),
   .core_irq  (core_irq)
);

// File: tb/pirq_router_tb.sv
module pirq_router_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG_LIMIT = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [31:0] irq_in = '0;
   logic [0:0]  bus_core = '0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_rdata;
   logic [29:0] core_irq;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   bit armed = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pirq_router u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .bus_core  (bus_core),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_be    (bus_be),
      .bus_rdata (bus_rdata),
      .core_irq  (core_irq)
   );

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_reg [2][8];
   logic [31:0] m_s1, m_s2;
   logic [29:0] m_out;

   function automatic logic [3:0] code_of(int c, int i);
      int a;
      a = 'h14 - 4 * (i / 8);
      return m_reg[c][a / 4][4 * (i % 8) +: 4];
   endfunction

   function automatic logic [31:0] exp_read(int c, int addr);
      int w;
      if ((addr % 4) != 0) return 32'h0;
      w = addr / 4;
      if (w == 1) return m_s2;
      if (w == 0 || (w >= 2 && w <= 5)) return m_reg[c][w];
      return 32'h0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++)
            for (int w = 0; w < 8; w++) m_reg[c][w] = '0;
         m_s1 = '0; m_s2 = '0; m_out = '0;
      end else begin
         logic [29:0] nxt;
         int w;
         nxt = '0;
         for (int c = 0; c < 2; c++)
            for (int i = 0; i < 32; i++)
               if (m_s2[i] && m_reg[c][0][i] && code_of(c, i) != 4'd0)
                  nxt[c*15 + int'(code_of(c, i)) - 1] = 1'b1;
         w = int'(bus_addr) / 4;
         if (bus_wr && bus_addr[1:0] == 2'b00 && (w == 0 || (w >= 2 && w <= 5)))
            for (int b = 0; b < 4; b++)
               if (bus_be[b]) m_reg[bus_core][w][8*b +: 8] = bus_wdata[8*b +: 8];
         m_s2 = m_s1;
         m_s1 = irq_in;
         m_out = nxt;
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
      end
   endtask

   // every cycle: outputs against the model (R7, R6)
   always @(negedge clk) begin
      if (armed && !done) chk("R7 per-cycle lines", {2'b00, core_irq}, {2'b00, m_out});
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WDOG_LIMIT && !done) begin
         n_err++;
         n_chk++;
         $display("FAIL R7 watchdog actual=%0d expected<%0d", cyc, WDOG_LIMIT);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic wr(int c, int addr, logic [31:0] d, logic [3:0] be);
      @(negedge clk);
      bus_core = c[0:0]; bus_addr = addr[4:0]; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(string tag, int c, int addr, logic [31:0] exp);
      @(negedge clk);
      bus_wr = 1'b0; bus_core = c[0:0]; bus_addr = addr[4:0];
      #1;
      chk(tag, bus_rdata, exp);
      if (exp !== exp_read(c, addr)) chk({tag, " model"}, exp_read(c, addr), exp);
   endtask

   task automatic set_in(logic [31:0] v);
      @(negedge clk);
      irq_in = v;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      #2 rst_n = 1'b0;
      armed = 1;
      idle(3);
      rst_n = 1'b1;

      // R9: reset state
      chk("R9 lines after reset", {2'b00, core_irq}, 32'h0);
      rd("R9 mask core0", 0, 'h00, 32'h0);
      rd("R9 route core1", 1, 'h14, 32'h0);

      // R4/R5: input 0 code 1 -> core0 line 0
      wr(0, 'h14, 32'h0000_0001, 4'hF);
      wr(0, 'h00, 32'h0000_0001, 4'hF);
      set_in(32'h0000_0001);
      idle(4);
      chk("R4 input0 code1 line0", {2'b00, core_irq}, 32'h0000_0001);
      rd("R5 readback 0x14", 0, 'h14, 32'h0000_0001);

      // R5: input 31 lives in the top nibble of 0x08, code 15 -> line 14
      wr(0, 'h08, 32'hF000_0000, 4'hF);
      wr(0, 'h00, 32'h8000_0001, 4'hF);
      set_in(32'h8000_0001);
      idle(4);
      chk("R5 input31 code15 line14", {2'b00, core_irq}, 32'h0000_4001);

      // R11: inputs 0 and 1 both on line 0
      wr(0, 'h14, 32'h0000_0011, 4'hF);
      wr(0, 'h00, 32'h8000_0003, 4'hF);
      set_in(32'h0000_0002);
      idle(4);
      chk("R11 shared line from input1", {2'b00, core_irq}, 32'h0000_0001);
      set_in(32'h0000_0003);
      idle(4);
      chk("R11 shared line both", {2'b00, core_irq}, 32'h0000_0001);

      // R6: core1 sends input0 to its line 2 (bit 17)
      wr(1, 'h14, 32'h0000_0003, 4'hF);
      wr(1, 'h00, 32'h0000_0001, 4'hF);
      set_in(32'h0000_0001);
      idle(4);
      chk("R6 per-core routing", {2'b00, core_irq}, 32'h0002_0001);

      // R3: mask cleared on core0 silences core0 only
      wr(0, 'h00, 32'h0, 4'hF);
      idle(3);
      chk("R3 mask off core0", {2'b00, core_irq}, 32'h0002_0000);

      // R4: code 0 disconnects
      wr(1, 'h14, 32'h0, 4'hF);
      idle(3);
      chk("R4 code0 disconnect", {2'b00, core_irq}, 32'h0);

      // R8: byte lanes
      wr(0, 'h10, 32'hAAAA_AAAA, 4'b0010);
      rd("R8 single lane", 0, 'h10, 32'h0000_AA00);
      wr(0, 'h10, 32'hFFFF_FFFF, 4'b0000);
      rd("R8 no lane", 0, 'h10, 32'h0000_AA00);

      // R2: status is read-only
      wr(0, 'h04, 32'hFFFF_FFFF, 4'hF);
      rd("R2 mask untouched", 0, 'h00, 32'h0);
      rd("R2 route untouched", 0, 'h08, 32'hF000_0000);
      rd("R2 status shows inputs", 0, 'h04, 32'h0000_0001);

      // R10: unmapped and unaligned
      wr(0, 'h18, 32'hFFFF_FFFF, 4'hF);
      rd("R10 gap reads zero", 0, 'h18, 32'h0);
      wr(0, 'h01, 32'hFFFF_FFFF, 4'hF);
      rd("R10 unaligned ignored", 0, 'h00, 32'h0);
      rd("R10 unaligned reads zero", 0, 'h15, 32'h0);

      // R1: status lags the input by two edges
      set_in(32'h0000_0020);
      rd("R1 status after one edge", 1, 'h04, 32'h0000_0001);
      rd("R1 status after two edges", 1, 'h04, 32'h0000_0020);

      // R7: output follows a mask write one edge later
      wr(0, 'h14, 32'h0020_0000, 4'hF);
      wr(0, 'h00, 32'h0000_0020, 4'hF);
      chk("R7 not yet after write", {2'b00, core_irq}, 32'h0);
      @(negedge clk);
      chk("R7 one edge after write", {2'b00, core_irq}, 32'h0000_0002);

      // random phase: input changes coinciding with writes (model compare, R7)
      for (int n = 0; n < 600; n++) begin
         @(negedge clk);
         irq_in   = $urandom;
         bus_wr   = ($urandom % 3) != 0;
         bus_core = 1'($urandom);
         bus_addr = 5'(($urandom % 8) * 4 + (($urandom % 16) == 0 ? 1 : 0));
         bus_wdata = $urandom & $urandom;
         bus_be   = 4'($urandom);
      end
      @(negedge clk);
      bus_wr = 1'b0;
      idle(4);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule